// File: doc/BRIEF.md
# Memory-to-Memory DMA Transfer Sequencer

This block copies a run of data words from one memory region to another. Each word is fetched from the source address into an internal holding register during a read phase. It is then written from that register to the destination address during a write phase. Both memory strobes are active low. A `ready` input held high stretches the strobe-active states so that slow memories can insert wait cycles. An active-low end-of-process input can cut the run short. Channel arbitration, bus ownership handshaking and programming of the channel registers sit outside the block. The per-channel address and count values arrive as flattened input buses.

A one-cycle `start` pulse in idle loads three working registers: a read pointer, a write pointer and a word counter. Two address-sourcing modes decide where these come from. In legacy mode the read pointer comes from channel 0's base address, the write pointer from channel 1's base address, and the count from channel 0. In per-channel mode all three come from the serviced channel: its base address, its destination address and its count. The states are IDLE, RD1, RD2, RD3, RD4, WR1, WR2, WR3 and WR4, with these transitions:

- IDLE→RD1 on `start`.
- RD1→RD2 and RD2→RD3, both unconditional.
- RD3→RD3 while `ready` is high, otherwise RD3→RD4.
- RD4→WR1 and WR1→WR2 and WR2→WR3, all unconditional.
- WR3→WR3 while `ready` is high, otherwise WR3→WR4.
- WR4→RD1 to continue the run, or WR4→IDLE to finish it.

Top module: `m2m_dma_seq`

## Requirements
- R1: After reset, both strobes are high, `addr_oe`, `data_oe`, `done` and `tc` are low, and the block is idle.
- R2: With `legacy_mode`=1 at `start`, words are read from consecutive addresses starting at channel 0's base, written to consecutive addresses starting at channel 1's base, and the word count comes from channel 0. `svc_chan` has no effect.
- R3: With `legacy_mode`=0 at `start`, the read base, write base and count come from channel `svc_chan`'s base address, destination address and count fields. Channel k occupies bits [k*width +: width] of each flattened bus.
- R4: Each read drives the read pointer with `mem_rd_n` high for one cycle (RD1). It then holds `mem_rd_n` low for one cycle (RD2) plus the RD3 cycles. RD3 repeats while `ready`=1.
- R5: In RD4, `data_in` is captured into the holding register. The word later written equals the word read from the source address.
- R6: Each write drives the write pointer for two cycles with both strobes high (WR1, WR2). It then holds `mem_wr_n` low in WR3, which repeats while `ready`=1, and releases it in WR4.
- R7: `data_oe` is high only in WR2, WR3 and WR4. `addr_oe` is high exactly when the block is not idle.
- R8: `mem_rd_n` and `mem_wr_n` are never low at the same time.
- R9: After each word, the read and write pointers each advance by one.
- R10: A count of N moves N+1 words. After the last word, `done` and `tc` pulse high together for one cycle and the block returns to idle.
- R11: If `eop_n` is low in any active state, the run ends after the current word's write, with `done`=1 and `tc`=0 unless the count was also exhausted.
- R12: `start` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled only in idle) |
| legacy_mode | input | 1 | 1: legacy address sourcing, 0: per-channel |
| svc_chan | input | CHW | Serviced channel index |
| ch_base_addr | input | NUM_CH*AW | Per-channel base/current addresses, flattened |
| ch_dst_addr | input | NUM_CH*AW | Per-channel destination addresses, flattened |
| ch_count | input | NUM_CH*CW | Per-channel word counts (N means N+1 words) |
| ready | input | 1 | High extends RD3/WR3 |
| eop_n | input | 1 | Active-low end-of-process |
| data_in | input | DW | Memory read data bus |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| addr_out | output | AW | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_out | output | DW | Write data (holding register) |
| data_oe | output | 1 | Write data tri-state enable |
| done | output | 1 | One-cycle completion pulse |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
On every cycle, the assertions check three things. The two strobes are mutually exclusive. The data and address drive enables agree with the strobes. `done` and `tc` are single-cycle pulses, with `tc` only alongside `done`. The assertions also cover how RD3 holds while `ready` is high and that a write strobe only falls after WR2. Several behaviours only the bench scenarios can show, because they need a memory model and known contents:

- the copied data and consecutive addressing;
- the different address sources of the two modes;
- strobe widths under several wait-cycle settings;
- the N+1 word count;
- early termination by end-of-process;
- rejection of a mid-run start.

// File: rtl/m2m_dma_pkg.sv
package m2m_dma_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_RD3,
        ST_RD4,
        ST_WR1,
        ST_WR2,
        ST_WR3,
        ST_WR4
    } seq_state_t;
endpackage

// File: rtl/m2m_addr_select.sv
module m2m_addr_select #(
    parameter int NUM_CH = 4,
    parameter int AW     = 16,
    parameter int CW     = 8,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 legacy_mode,
    input  logic [CHW-1:0]       svc_chan,
    input  logic [NUM_CH*AW-1:0] ch_base_addr,
    input  logic [NUM_CH*AW-1:0] ch_dst_addr,
    input  logic [NUM_CH*CW-1:0] ch_count,
    output logic [AW-1:0]        sel_rd,
    output logic [AW-1:0]        sel_wr,
    output logic [CW-1:0]        sel_cnt
);
    // Legacy sourcing: channel 0 feeds the read side, channel 1 the write side.
    always_comb begin
        if (legacy_mode) begin
            sel_rd  = ch_base_addr[0 +: AW];
            sel_wr  = ch_base_addr[AW +: AW];
            sel_cnt = ch_count[0 +: CW];
        end else begin
            sel_rd  = ch_base_addr[svc_chan*AW +: AW];
            sel_wr  = ch_dst_addr[svc_chan*AW +: AW];
            sel_cnt = ch_count[svc_chan*CW +: CW];
        end
    end
endmodule

// File: rtl/m2m_work_regs.sv
module m2m_work_regs #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] ld_rd,
    input  logic [AW-1:0] ld_wr,
    input  logic [CW-1:0] ld_cnt,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_ptr,
    output logic          cnt_zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            rd_ptr <= ld_rd;
            wr_ptr <= ld_wr;
            cnt_q  <= ld_cnt;
        end else if (step) begin
            rd_ptr <= rd_ptr + AW'(1);
            wr_ptr <= wr_ptr + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    // Decrementing from zero would underflow: this is the last word.
    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/m2m_dma_seq.sv
module m2m_dma_seq
    import m2m_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int CW     = 8,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 legacy_mode,
    input  logic [CHW-1:0]       svc_chan,
    input  logic [NUM_CH*AW-1:0] ch_base_addr,
    input  logic [NUM_CH*AW-1:0] ch_dst_addr,
    input  logic [NUM_CH*CW-1:0] ch_count,
    input  logic                 ready,
    input  logic                 eop_n,
    input  logic [DW-1:0]        data_in,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic [AW-1:0]        addr_out,
    output logic                 addr_oe,
    output logic [DW-1:0]        data_out,
    output logic                 data_oe,
    output logic                 done,
    output logic                 tc
);
    seq_state_t    state, state_nx;
    logic [AW-1:0] sel_rd, sel_wr, rd_ptr, wr_ptr;
    logic [CW-1:0] sel_cnt;
    logic          cnt_zero, load, step, finish, eop_seen;
    logic [DW-1:0] hold_q;

    m2m_addr_select #(.NUM_CH(NUM_CH), .AW(AW), .CW(CW)) u_sel (
        .legacy_mode (legacy_mode),
        .svc_chan    (svc_chan),
        .ch_base_addr(ch_base_addr),
        .ch_dst_addr (ch_dst_addr),
        .ch_count    (ch_count),
        .sel_rd      (sel_rd),
        .sel_wr      (sel_wr),
        .sel_cnt     (sel_cnt)
    );

    m2m_work_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .ld_rd   (sel_rd),
        .ld_wr   (sel_wr),
        .ld_cnt  (sel_cnt),
        .rd_ptr  (rd_ptr),
        .wr_ptr  (wr_ptr),
        .cnt_zero(cnt_zero)
    );

    assign load   = (state == ST_IDLE) && start;
    assign step   = (state == ST_WR4);
    assign finish = cnt_zero || eop_seen || !eop_n;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RD1;
            ST_RD1:  state_nx = ST_RD2;
            ST_RD2:  state_nx = ST_RD3;
            ST_RD3:  if (!ready) state_nx = ST_RD4;
            ST_RD4:  state_nx = ST_WR1;
            ST_WR1:  state_nx = ST_WR2;
            ST_WR2:  state_nx = ST_WR3;
            ST_WR3:  if (!ready) state_nx = ST_WR4;
            ST_WR4:  state_nx = finish ? ST_IDLE : ST_RD1;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and sequencing side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            eop_seen <= 1'b0;
            hold_q   <= '0;
            done     <= 1'b0;
            tc       <= 1'b0;
        end else begin
            state <= state_nx;
            if (load)
                eop_seen <= 1'b0;
            else if (state != ST_IDLE && !eop_n)
                eop_seen <= 1'b1;
            if (state == ST_RD4)
                hold_q <= data_in;
            done <= step && finish;
            tc   <= step && cnt_zero;
        end
    end

    // Output decode
    always_comb begin
        mem_rd_n = 1'b1;
        mem_wr_n = 1'b1;
        addr_oe  = 1'b1;
        data_oe  = 1'b0;
        addr_out = rd_ptr;
        unique case (state)
            ST_IDLE: begin addr_oe = 1'b0; addr_out = '0; end
            ST_RD1, ST_RD4: ;
            ST_RD2, ST_RD3: mem_rd_n = 1'b0;
            ST_WR1:  addr_out = wr_ptr;
            ST_WR2, ST_WR4: begin addr_out = wr_ptr; data_oe = 1'b1; end
            ST_WR3:  begin addr_out = wr_ptr; data_oe = 1'b1; mem_wr_n = 1'b0; end
            default: begin addr_oe = 1'b0; addr_out = '0; end
        endcase
    end

    assign data_out = hold_q;

    // Assertions
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));
    assert_data_oe_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> mem_rd_n);
    assert_addr_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> (mem_rd_n && mem_wr_n && !data_oe));
    assert_wr_strobe_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> data_oe);
    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD3 && ready) |=> (state == ST_RD3 && !mem_rd_n));
    assert_wr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> ($past(state) == ST_WR2));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_tc_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (done && !addr_oe));
    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD2) |=> (state == ST_RD3));
endmodule

// File: tb/m2m_dma_seq_tb_top.sv
module m2m_dma_seq_tb_top;
    localparam int NUM_CH = 4;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int CHW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic legacy_mode = 1'b0;
    logic [CHW-1:0] svc_chan = '0;
    logic [NUM_CH*AW-1:0] ch_base_addr = '0;
    logic [NUM_CH*AW-1:0] ch_dst_addr = '0;
    logic [NUM_CH*CW-1:0] ch_count = '0;
    logic ready;
    logic eop_n = 1'b1;
    logic [DW-1:0] data_in;
    logic mem_rd_n, mem_wr_n, addr_oe, data_oe, done, tc;
    logic [AW-1:0] addr_out;
    logic [DW-1:0] data_out;

    int errors = 0;
    int checks = 0;
    int wait_cycles = 0;
    int lo_cnt = 0;
    int wr_seen = 0;
    logic [DW-1:0] mem [256];
    logic [AW+DW-1:0] exp_q [$];

    always #5 clk = ~clk;

    m2m_dma_seq #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .legacy_mode(legacy_mode),
        .svc_chan(svc_chan), .ch_base_addr(ch_base_addr), .ch_dst_addr(ch_dst_addr),
        .ch_count(ch_count), .ready(ready), .eop_n(eop_n), .data_in(data_in),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .addr_out(addr_out),
        .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe),
        .done(done), .tc(tc)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 17) ^ 8'h5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: wait-cycle counter drives ready while a strobe is low
    always @(posedge clk) begin
        if (!mem_rd_n || !mem_wr_n) lo_cnt <= lo_cnt + 1;
        else lo_cnt <= 0;
    end
    assign ready = (!mem_rd_n || !mem_wr_n) && (lo_cnt < wait_cycles);
    assign data_in = mem[addr_out[7:0]];

    // Monitor: strobe widths, enables, write scoreboard
    int rd_w = 0, wr_w = 0;
    logic prev_wr_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_rd_n) rd_w++;
            else if (rd_w != 0) begin
                check(rd_w == 1 + ((wait_cycles > 1) ? wait_cycles : 1), "R4 read strobe width",
                      rd_w, 1 + ((wait_cycles > 1) ? wait_cycles : 1));
                rd_w = 0;
            end
            if (!mem_wr_n) wr_w++;
            else if (wr_w != 0) begin
                check(wr_w == wait_cycles + 1, "R6 write strobe width", wr_w, wait_cycles + 1);
                wr_w = 0;
            end
            if (!mem_rd_n) check(addr_oe && !data_oe, "R7 enables during read", {addr_oe, data_oe}, 2'b10);
            if (!mem_rd_n && !mem_wr_n) check(0, "R8 strobe overlap", 0, 1);
            if (!mem_wr_n && prev_wr_n) begin
                check(addr_oe && data_oe, "R7 enables during write", {addr_oe, data_oe}, 2'b11);
                if (exp_q.size() == 0) begin
                    check(0, "R10/R11 unexpected extra write", int'(addr_out), 0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check(addr_out == e[AW+DW-1:DW], "R9 write address (R2/R3 source)",
                          int'(addr_out), int'(e[AW+DW-1:DW]));
                    check(data_out == e[DW-1:0], "R5 write data", int'(data_out), int'(e[DW-1:0]));
                end
                mem[addr_out[7:0]] = data_out;
                wr_seen++;
            end
            prev_wr_n = mem_wr_n;
        end
    end

    // Driver: program inputs, push expected writes, run to completion
    task automatic run_xfer(input bit leg, input int chn, input int rbase, input int wbase,
                            input int nwords, input bit exp_tc, input int eop_after,
                            input bit busy_start, input string req);
        for (int i = 0; i < nwords; i++)
            exp_q.push_back({AW'(wbase + i), pat(rbase + i)});
        wr_seen = 0;
        @(negedge clk);
        legacy_mode = leg;
        svc_chan = CHW'(chn);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(addr_oe == 1'b1, {req, " R7 addr_oe busy"}, addr_oe, 1);
        if (busy_start) begin
            repeat (3) @(negedge clk);
            legacy_mode = ~leg;
            svc_chan = CHW'(chn + 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 2000; t++) begin
            if (eop_after > 0 && wr_seen == eop_after && eop_n) begin
                eop_n = 1'b0;
                @(negedge clk);
                eop_n = 1'b1;
                eop_after = 0;
            end
            if (done) break;
            @(negedge clk);
        end
        check(done == 1'b1, {req, " R10 done pulse"}, done, 1);
        check(tc == exp_tc, {req, " R10/R11 tc"}, tc, exp_tc);
        @(negedge clk);
        check(done == 1'b0 && tc == 1'b0, {req, " R10 one-cycle pulse"}, {done, tc}, 0);
        check(addr_oe == 1'b0 && mem_rd_n && mem_wr_n, {req, " R7 idle after run"}, addr_oe, 0);
        check(exp_q.size() == 0, {req, " R10 all words written"}, exp_q.size(), 0);
        check(wr_seen == nwords, {req, " R10/R11 word count"}, wr_seen, nwords);
        for (int i = 0; i < nwords; i++)
            check(mem[(wbase + i) & 8'hFF] == pat(rbase + i), {req, " R5 memory copy"},
                  int'(mem[(wbase + i) & 8'hFF]), int'(pat(rbase + i)));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        // channel 0..3 registers
        ch_base_addr = {16'h0030, 16'h0020, 16'h0080, 16'h0010};
        ch_dst_addr  = {16'h00C0, 16'h00A0, 16'h00E0, 16'h00F0};
        ch_count     = {8'd5, 8'd2, 8'd6, 8'd3};
        repeat (3) @(negedge clk);
        check(mem_rd_n && mem_wr_n && !addr_oe && !data_oe && !done && !tc, "R1 reset state",
              {mem_rd_n, mem_wr_n, addr_oe, data_oe, done, tc}, 6'b110000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!addr_oe && mem_rd_n && mem_wr_n, "R1 idle after reset", addr_oe, 0);

        // R2: legacy, channel 2 selected but ignored, no wait states
        wait_cycles = 0;
        run_xfer(1'b1, 2, 16'h0010, 16'h0080, 4, 1'b1, 0, 1'b0, "R2 legacy W0");
        // R3: per-channel mode, channel 2, two wait cycles
        wait_cycles = 2;
        run_xfer(1'b0, 2, 16'h0020, 16'h00A0, 3, 1'b1, 0, 1'b0, "R3 chan2 W2");
        // R11: per-channel channel 3, eop after second write
        wait_cycles = 1;
        run_xfer(1'b0, 3, 16'h0030, 16'h00C0, 2, 1'b0, 2, 1'b0, "R11 eop chan3 W1");
        // R12: legacy with count 0 and a start pulse mid-run
        ch_count[7:0] = 8'd0;
        ch_base_addr[15:0] = 16'h0040;
        ch_base_addr[31:16] = 16'h0090;
        wait_cycles = 3;
        run_xfer(1'b1, 0, 16'h0040, 16'h0090, 1, 1'b1, 0, 1'b1, "R12 busy start W3");
        repeat (20) @(negedge clk);
        check(!addr_oe && !done, "R12 no restart from busy start", {addr_oe, done}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule